// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block feeds an 8-bit parallel-input digital-to-analog converter whose input latch passes data straight through while its active-low select and write strobes are both low, and freezes the bus value as soon as either strobe goes high again. Samples arrive on a valid/ready stream. Each accepted sample is put on the converter's data bus, and the sequencer then runs a fixed strobe pattern so that the converter's minimum timing is met with margin at the chosen system clock.

All intervals are given in nanoseconds and turned into whole clock cycles when the design is built: each is the ceiling of the required time over the clock period, with a minimum of one cycle. An elaboration option selects bipolar operation. In that mode the incoming sample is a signed two's-complement number and is recoded to offset binary, so that a zero sample gives mid-scale code 0x80, the most negative sample gives 0x00, and the most positive gives 0xFF. With the option off, the sample passes through unchanged.

Top module: `dac_write_seq`

## Requirements
- R1: While reset is high at a clock edge, the sequencer returns to idle, both strobes go high, the data bus goes to zero, ready goes high and done goes low.
- R2: ready is high only while the sequencer is idle with both strobes high, and a sample is taken at a clock edge where valid and ready are both high.
- R3: The data bus holds the new value from the edge where select falls and does not change in any cycle where select was already low.
- R4: The write strobe stays low for at least TW_WR_NS nanoseconds (a whole number of clock periods).
- R5: Select is low at least TSU_CS_NS before the write strobe rises, and select rises at the same clock edge as the write strobe.
- R6: The data bus is stable at least TSU_D_NS before the write strobe rises and stays unchanged at least TH_D_NS after it rises.
- R7: With the bipolar option off, the value frozen in the converter equals the accepted sample bit for bit.
- R8: With the bipolar option on, the frozen value is the signed sample plus 128, modulo 256: sample -128 gives 0x00, 0 gives 0x80, +127 gives 0xFF.
- R9: done is high for exactly one cycle per accepted sample, after both strobes have risen, while both strobes are high.
- R10: The write strobe is never low while select is high.
- R11: valid raised while ready is low has no effect: no extra write is made and the bus keeps the sample being written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready (idle) |
| s_data | input | DATA_W | Sample, unsigned or two's complement |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_wr_n | output | 1 | Converter write strobe, active low |
| dac_db | output | DATA_W | Converter data bus |
| done | output | 1 | One-cycle pulse at the end of the data hold |

## Verification
A wrong sequencer state shows at the ports within one cycle: a state that skips or shortens setup or the write pulse makes the write strobe rise too early relative to select falling, and a state that reloads the data register while select is low changes the bus inside the transparent window. A wrong interval count shows at the next rising edge of the write strobe as a short pulse or short setup, and at the next bus change as a short hold. A wrong code mapping shows at the first write as a frozen value that differs from the sample or its offset-binary form.

// File: rtl/dws_pkg.sv
package dws_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WRLOW,
      ST_RELEASE,
      ST_HOLD
   } dws_state_e;

   // whole clock cycles covering a time in ns, never below one
   function automatic int cyc_ceil(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dws_code_map.sv
module dws_code_map #(
   parameter int DATA_W  = 8,
   parameter bit BIPOLAR = 1'b0
) (
   input  logic [DATA_W-1:0] smp,
   output logic [DATA_W-1:0] code
);
   localparam int MSB = DATA_W - 1;

   generate
      if (BIPOLAR) begin : g_offset
         // two's complement to offset binary: flip the sign bit
         assign code = {~smp[MSB], smp[MSB-1:0]};
      end else begin : g_straight
         assign code = smp;
      end
   endgenerate

endmodule

// File: rtl/dws_interval_timer.sv
module dws_interval_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || restart) begin
         cnt_q <= '0;
      end else if (cnt_q != limit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired = (cnt_q == limit);

   // R4: the count never runs past the window of the current state
   a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= limit);

endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq
   import dws_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CLK_NS    = 10,
   parameter int TSU_CS_NS = 40,
   parameter int TW_WR_NS  = 40,
   parameter int TSU_D_NS  = 25,
   parameter int TH_D_NS   = 10,
   parameter bit BIPOLAR   = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              s_valid,
   output logic              s_ready,
   input  logic [DATA_W-1:0] s_data,
   output logic              dac_cs_n,
   output logic              dac_wr_n,
   output logic [DATA_W-1:0] dac_db,
   output logic              done
);
   localparam int CS_C    = cyc_ceil(TSU_CS_NS, CLK_NS);
   localparam int WR_C    = cyc_ceil(TW_WR_NS, CLK_NS);
   localparam int DS_C    = cyc_ceil(TSU_D_NS, CLK_NS);
   localparam int DH_C    = cyc_ceil(TH_D_NS, CLK_NS);
   localparam int PRE_C   = imax(CS_C, DS_C);
   // cycles before the write strobe falls; the write pulse counts toward setup
   localparam int SETUP_C = (PRE_C > WR_C) ? PRE_C - WR_C : 1;
   // the release cycle already gives one cycle of hold
   localparam int HOLD_C  = (DH_C > 1) ? DH_C - 1 : 1;
   localparam int MAX_C   = imax(imax(SETUP_C, WR_C), HOLD_C);
   localparam int CNT_W   = (MAX_C < 2) ? 1 : $clog2(MAX_C);

   generate
      if (DATA_W < 2) begin : g_chk_width
         $error("dac_write_seq: DATA_W must be at least 2");
      end
      if (CLK_NS < 1) begin : g_chk_clk
         $error("dac_write_seq: CLK_NS must be positive");
      end
   endgenerate

   dws_state_e          st_q, st_nxt;
   logic [DATA_W-1:0]   code;
   logic [DATA_W-1:0]   db_q;
   logic [CNT_W-1:0]    lim;
   logic                tmr_exp;
   logic                cs_n_q, wr_n_q;
   logic                take;

   dws_code_map #(.DATA_W(DATA_W), .BIPOLAR(BIPOLAR)) u_map (
      .smp  (s_data),
      .code (code)
   );

   always_comb begin
      case (st_q)
         ST_SETUP: lim = CNT_W'(SETUP_C - 1);
         ST_WRLOW: lim = CNT_W'(WR_C - 1);
         ST_HOLD:  lim = CNT_W'(HOLD_C - 1);
         default:  lim = '0;
      endcase
   end

   dws_interval_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .restart (st_nxt != st_q),
      .limit   (lim),
      .expired (tmr_exp)
   );

   assign take = (st_q == ST_IDLE) && s_valid;

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         ST_IDLE:    if (s_valid) st_nxt = ST_SETUP;
         ST_SETUP:   if (tmr_exp) st_nxt = ST_WRLOW;
         ST_WRLOW:   if (tmr_exp) st_nxt = ST_RELEASE;
         ST_RELEASE: st_nxt = ST_HOLD;
         ST_HOLD:    if (tmr_exp) st_nxt = ST_IDLE;
         default:    st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= ST_IDLE;
         cs_n_q <= 1'b1;
         wr_n_q <= 1'b1;
         db_q   <= '0;
      end else begin
         st_q   <= st_nxt;
         cs_n_q <= !((st_nxt == ST_SETUP) || (st_nxt == ST_WRLOW));
         wr_n_q <= (st_nxt != ST_WRLOW);
         if (take) db_q <= code;
      end
   end

   assign s_ready  = (st_q == ST_IDLE);
   assign dac_cs_n = cs_n_q;
   assign dac_wr_n = wr_n_q;
   assign dac_db   = db_q;
   assign done     = (st_q == ST_HOLD) && tmr_exp;

   // R1: reset puts both strobes high and clears the bus
   a_r1_reset_state: assert property (@(posedge clk)
      rst |=> (dac_cs_n && dac_wr_n && (dac_db == '0)));

   // R2: ready only with both strobes idle
   a_r2_ready_idle: assert property (@(posedge clk) disable iff (rst)
      s_ready |-> (dac_cs_n && dac_wr_n));

   // R3: no bus change while select stays low
   a_r3_db_frozen: assert property (@(posedge clk) disable iff (rst)
      (!dac_cs_n && $past(!dac_cs_n)) |-> $stable(dac_db));

   // R5: select released together with the write strobe
   a_r5_joint_release: assert property (@(posedge clk) disable iff (rst)
      $rose(dac_wr_n) |-> $rose(dac_cs_n));

   // R9: done lasts a single cycle and comes with both strobes high
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   a_r9_done_idle_strobes: assert property (@(posedge clk) disable iff (rst)
      done |-> (dac_cs_n && dac_wr_n));

   // R10: write low only inside select low
   a_r10_wr_inside_cs: assert property (@(posedge clk) disable iff (rst)
      !dac_wr_n |-> !dac_cs_n);

endmodule

// File: tb/dac_write_seq_bench.sv
module dws_mon #(
   parameter int CLK_NS    = 10,
   parameter int TSU_CS_NS = 40,
   parameter int TW_WR_NS  = 40,
   parameter int TSU_D_NS  = 25,
   parameter int TH_D_NS   = 10,
   parameter bit BIPOLAR   = 1'b0
) (
   input logic       clk,
   input logic       rst,
   input logic       cs_n,
   input logic       wr_n,
   input logic [7:0] db,
   input logic       done,
   input logic       ready
);
   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];

   logic       p_cs = 1'b1, p_wr = 1'b1, p_done = 1'b0;
   logic [7:0] p_db = 8'h00;
   int cs_low = 0, wr_low = 0, db_same = 0, since_rise = -1;
   bit await_done = 1'b0;

   function automatic void push(input logic [7:0] v);
      exp_q.push_back(v);
   endfunction

   function automatic int pending();
      return exp_q.size();
   endfunction

   function automatic void chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s (%s) actual=%0d expected=%0d at %0t", req,
                  BIPOLAR ? "bipolar" : "unipolar", act, expv, $time);
      end
   endfunction

   always @(negedge clk) begin
      if (rst) begin
         p_cs = 1'b1; p_wr = 1'b1; p_db = db; p_done = 1'b0;
         cs_low = 0; wr_low = 0; db_same = 0; since_rise = -1;
         await_done = 1'b0;
      end else begin
         if (!p_wr && wr_n) begin
            chk(wr_low * CLK_NS >= TW_WR_NS, "R4 write pulse ns", wr_low * CLK_NS, TW_WR_NS);
            chk(cs_low * CLK_NS >= TSU_CS_NS, "R5 select setup ns", cs_low * CLK_NS, TSU_CS_NS);
            chk(cs_n == 1'b1, "R5 select rises with write", int'(cs_n), 1);
            chk(db_same * CLK_NS >= TSU_D_NS, "R6 data setup ns", db_same * CLK_NS, TSU_D_NS);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R11 unexpected write", int'(p_db), -1);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(p_db == e, BIPOLAR ? "R8 frozen code" : "R7 frozen code", int'(p_db), int'(e));
            end
            since_rise = 0;
            await_done = 1'b1;
         end else if (since_rise >= 0) begin
            since_rise++;
         end

         if (db !== p_db) begin
            chk(!(!cs_n && !p_cs), "R3 bus moved while selected", int'(db), int'(p_db));
            if (since_rise >= 0)
               chk(since_rise * CLK_NS >= TH_D_NS, "R6 data hold ns", since_rise * CLK_NS, TH_D_NS);
            db_same = 1;
         end else begin
            db_same++;
         end

         if (!wr_n && cs_n) chk(1'b0, "R10 write without select", 0, 1);
         if (ready && !(cs_n && wr_n)) chk(1'b0, "R2 ready while busy", 1, 0);

         if (done) begin
            chk(await_done, "R9 done without write", 0, 1);
            chk(cs_n && wr_n, "R9 done with strobes high", int'({cs_n, wr_n}), 3);
            chk(!p_done, "R9 done single cycle", int'(p_done), 0);
            await_done = 1'b0;
         end

         cs_low = cs_n ? 0 : cs_low + 1;
         wr_low = wr_n ? 0 : wr_low + 1;
         p_cs = cs_n; p_wr = wr_n; p_db = db; p_done = done;
      end
   end
endmodule

module dac_write_seq_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic       va = 1'b0, vb = 1'b0;
   logic [7:0] da = 8'h00, db_in = 8'h00;
   logic       ra, rb, csa, csb, wra, wrb, dna, dnb;
   logic [7:0] qa, qb;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   dac_write_seq #(.CLK_NS(CLK_PERIOD)) u_dac_write_seq (
      .clk(clk), .rst(rst), .s_valid(va), .s_ready(ra), .s_data(da),
      .dac_cs_n(csa), .dac_wr_n(wra), .dac_db(qa), .done(dna)
   );

   dac_write_seq #(.CLK_NS(7), .TSU_CS_NS(60), .BIPOLAR(1'b1)) u_dac_write_seq_bip (
      .clk(clk), .rst(rst), .s_valid(vb), .s_ready(rb), .s_data(db_in),
      .dac_cs_n(csb), .dac_wr_n(wrb), .dac_db(qb), .done(dnb)
   );

   dws_mon #(.CLK_NS(CLK_PERIOD)) u_mon_a (
      .clk(clk), .rst(rst), .cs_n(csa), .wr_n(wra), .db(qa), .done(dna), .ready(ra)
   );

   dws_mon #(.CLK_NS(7), .TSU_CS_NS(60), .BIPOLAR(1'b1)) u_mon_b (
      .clk(clk), .rst(rst), .cs_n(csb), .wr_n(wrb), .db(qb), .done(dnb), .ready(rb)
   );

   function automatic void chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endfunction

   function automatic void summary();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk + u_mon_a.n_chk + u_mon_b.n_chk,
                  n_bad + u_mon_a.n_bad + u_mon_b.n_bad);
      end
   endfunction

   // driver: called on a falling edge, returns on the falling edge after acceptance
   task automatic send_a(input logic [7:0] v);
      u_mon_a.push(v);
      va = 1'b1; da = v;
      forever begin
         bit acc;
         acc = ra;
         @(negedge clk);
         if (acc) break;
      end
      va = 1'b0;
   endtask

   task automatic send_b(input logic signed [7:0] s);
      int e;
      e = (int'(s) + 128) % 256;   // offset binary expectation
      u_mon_b.push(8'(e));
      vb = 1'b1; db_in = s;
      forever begin
         bit acc;
         acc = rb;
         @(negedge clk);
         if (acc) break;
      end
      vb = 1'b0;
   endtask

   task automatic wait_done_a();
      while (!dna) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_done_b();
      while (!dnb) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state visible while reset is still applied
      chk(csa && wra, "R1 strobes high in reset", int'({csa, wra}), 3);
      chk(qa == 8'h00, "R1 bus cleared in reset", int'(qa), 0);
      chk(ra && !dna, "R1 ready, no done in reset", int'({ra, dna}), 2);
      chk(csb && wrb && qb == 8'h00, "R1 second unit reset", int'(qb), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(ra && rb, "R2 ready after reset", int'({ra, rb}), 3);

      // unipolar: varied patterns, back to back
      send_a(8'hA5);
      chk(!ra, "R2 ready drops after acceptance", int'(ra), 0);
      chk(!csa && qa == 8'hA5, "R3 bus driven as select falls", int'(qa), 8'hA5);
      send_a(8'h5A);
      send_a(8'hFF);
      send_a(8'h00);
      send_a(8'h01);
      send_a(8'h80);
      wait_done_a();

      // R11: valid pulse while busy must be ignored
      send_a(8'h3C);
      va = 1'b1; da = 8'hC3;
      @(negedge clk);
      va = 1'b0; da = 8'h00;
      wait_done_a();
      chk(qa == 8'h3C, "R11 bus keeps written sample", int'(qa), 8'h3C);
      repeat (20) @(negedge clk);
      chk(u_mon_a.pending() == 0, "R11 no stray or missing write", u_mon_a.pending(), 0);
      chk(ra && csa && wra, "R11 idle afterwards", int'({ra, csa, wra}), 7);

      // bipolar: signed samples to offset binary
      send_b(-8'sd128);
      wait_done_b();
      chk(qb == 8'h00, "R8 most negative gives 0x00", int'(qb), 0);
      send_b(8'sd0);
      wait_done_b();
      chk(qb == 8'h80, "R8 zero gives 0x80", int'(qb), 8'h80);
      send_b(8'sd127);
      wait_done_b();
      chk(qb == 8'hFF, "R8 most positive gives 0xFF", int'(qb), 8'hFF);
      send_b(-8'sd1);
      send_b(8'sd1);
      send_b(8'sd85);
      wait_done_b();
      repeat (20) @(negedge clk);
      chk(u_mon_b.pending() == 0, "R8 all bipolar writes seen", u_mon_b.pending(), 0);
      chk(u_mon_a.pending() == 0, "R7 all unipolar writes seen", u_mon_a.pending(), 0);

      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         summary();
         $finish;
      end
   end
endmodule